// File: doc/BRIEF.md
# Control-Write Sequencer for a Serial Controller

This block sits between a CPU bus and the configuration registers of a programmable serial controller. It watches active-low chip-select, write and read strobes, a control/data select line and an 8-bit write bus. It decides where each write goes. One control address carries three kinds of word, and their meaning depends on how far programming has progressed. After reset, the first control write is the mode word. If the mode selects synchronous operation, one or two sync characters follow. After that, every control write is a command. Any command that asks for an internal reset restarts this sequence.

Data writes become a one-cycle strobe toward the transmitter, which carries the written byte. Data reads become a one-cycle strobe toward the receiver. The bus strobes are asynchronous to the block clock. Each strobe is synchronised, and the block acts on its rising edge, so one bus cycle produces exactly one action no matter how long the strobe stays low.

The output `mode_done` is low while the block waits for a mode word. The status logic outside this block uses it to force every ready flag to zero in that state.

Top module: `ctl_write_seq`

## Requirements
- R1: While `rst` is high, and after it falls, `mode_q`, `cmd_q`, `sync1_q` and `sync2_q` are zero, `mode_done` is low and neither strobe pulses.
- R2: The first accepted control write (`cs_n`=0, `cd_sel`=1) after any reset is stored in `mode_q`, and `mode_done` goes high.
- R3: When `mode_q[1:0]` is not 00 (asynchronous), each later accepted control write is stored in `cmd_q`. `mode_q`, `sync1_q` and `sync2_q` keep their values.
- R4: When `mode_q[1:0]` is 00 (synchronous), `mode_q[7:6]` gives the number of sync characters: 00 means none, 01 means one, 10 or 11 means two. They are written in order, first to `sync1_q` and then to `sync2_q`. After the last one, control writes go to `cmd_q`.
- R5: A control write in the command state with bit 6 set clears `cmd_q` to zero and sends the block back to waiting for a mode word. The next control write is stored in `mode_q`.
- R6: An accepted data write (`cs_n`=0, `cd_sel`=0) while `mode_done` is high gives exactly one `tx_wr_stb` pulse, and `tx_data` equals the written byte during that pulse. While waiting for a mode word, a data write gives no pulse.
- R7: A write or read with `cs_n` high changes no register and gives no strobe.
- R8: A read with `cs_n`=0 and `cd_sel`=0 gives exactly one `rx_rd_stb` pulse. A control read gives none.
- R9: A write strobe held low for any number of clocks has exactly one effect, applied within four clocks after `wr_n` rises.
- R10: `mode_done` is low exactly while the block waits for a mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cd_sel | input | 1 | 1 = control, 0 = data |
| wdata | input | 8 | CPU write data |
| mode_q | output | 8 | Latched mode word |
| cmd_q | output | 8 | Latched command word |
| sync1_q | output | 8 | First sync character |
| sync2_q | output | 8 | Second sync character |
| tx_wr_stb | output | 1 | One-cycle transmit-data write pulse |
| tx_data | output | 8 | Byte for the transmitter |
| rx_rd_stb | output | 1 | One-cycle receive-data read pulse |
| mode_done | output | 1 | Mode word received; low gates status ready flags |

## Verification
The bench targets several points where the routing could go wrong:
- A synchronous mode with a zero sync count. A design that miscounts here would swallow the first command as a sync character.
- A single-sync mode. A faulty design would wrongly expect a second sync character.
- An internal-reset command. A design that mishandles it would keep the stale command, or treat the next mode word as a command.
- Long write strobes. A design that fires on the level rather than the edge would repeat the write.
- Deselected cycles and data writes made before any mode word. A faulty design would wrongly latch these or pulse the transmitter.

A seeded random mix of every bus cycle type is then checked against a reference model of the sequence.

// File: rtl/ctl_write_seq.sv
module ctl_write_seq #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          cd_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] sync1_q,
  output logic [DW-1:0] sync2_q,
  output logic          tx_wr_stb,
  output logic [DW-1:0] tx_data,
  output logic          rx_rd_stb,
  output logic          mode_done
);
  localparam int IRST_BIT = 6;
  localparam int CNT_LO   = 6;
  localparam int S        = SYNC_STAGES;

  typedef enum logic [1:0] {ST_MODE, ST_SYNC1, ST_SYNC2, ST_CMD} st_t;
  st_t st;

  logic [S:0] wr_sh, rd_sh;
  logic          cap_cs, cap_cd, rcap_cs, rcap_cd;
  logic [DW-1:0] cap_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sh <= '1;
      rd_sh <= '1;
    end else begin
      wr_sh <= {wr_sh[S-1:0], wr_n};
      rd_sh <= {rd_sh[S-1:0], rd_n};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_cs  <= 1'b1;
      cap_cd  <= 1'b0;
      cap_d   <= '0;
      rcap_cs <= 1'b1;
      rcap_cd <= 1'b0;
    end else begin
      if (!wr_n) begin
        cap_cs <= cs_n;
        cap_cd <= cd_sel;
        cap_d  <= wdata;
      end
      if (!rd_n) begin
        rcap_cs <= cs_n;
        rcap_cd <= cd_sel;
      end
    end
  end

  wire wr_rise = wr_sh[S-1] & ~wr_sh[S];
  wire rd_rise = rd_sh[S-1] & ~rd_sh[S];
  wire wr_go   = wr_rise & ~cap_cs;
  wire ctl_go  = wr_go & cap_cd;
  wire dat_go  = wr_go & ~cap_cd;
  wire [1:0] sync_cnt = mode_q[CNT_LO+1:CNT_LO];

  assign mode_done = (st != ST_MODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_MODE;
      mode_q    <= '0;
      cmd_q     <= '0;
      sync1_q   <= '0;
      sync2_q   <= '0;
      tx_wr_stb <= 1'b0;
      tx_data   <= '0;
      rx_rd_stb <= 1'b0;
    end else begin
      tx_wr_stb <= dat_go && mode_done;
      rx_rd_stb <= rd_rise && !rcap_cs && !rcap_cd;
      if (dat_go && mode_done) tx_data <= cap_d;
      if (ctl_go) begin
        case (st)
          ST_MODE: begin
            mode_q <= cap_d;
            st <= (cap_d[1:0] == 2'b00 && cap_d[CNT_LO+1:CNT_LO] != 2'b00) ? ST_SYNC1 : ST_CMD;
          end
          ST_SYNC1: begin
            sync1_q <= cap_d;
            st <= (sync_cnt[1]) ? ST_SYNC2 : ST_CMD;
          end
          ST_SYNC2: begin
            sync2_q <= cap_d;
            st <= ST_CMD;
          end
          default: begin
            if (cap_d[IRST_BIT]) begin
              cmd_q <= '0;
              st <= ST_MODE;
            end else begin
              cmd_q <= cap_d;
            end
          end
        endcase
      end
    end
  end

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CMD && $past(st) == ST_CMD) |-> $stable(mode_q));

  p_irst_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_go && st == ST_CMD && cap_d[IRST_BIT]) |=> (st == ST_MODE && cmd_q == '0));

  p_tx_armed_r6: assert property (@(posedge clk) disable iff (rst)
    tx_wr_stb |-> $past(st != ST_MODE));

  p_deselect_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && cap_cs) |=> ($stable({mode_q, cmd_q, sync1_q, sync2_q}) && $stable(st) && !tx_wr_stb));

  p_single_tx_r9: assert property (@(posedge clk) disable iff (rst)
    tx_wr_stb |=> !tx_wr_stb);

  p_single_rx_r8: assert property (@(posedge clk) disable iff (rst)
    rx_rd_stb |=> !rx_rd_stb);
endmodule

// File: tb/ctl_write_seq_test.sv
module ctl_write_seq_test;
  logic clk = 0, rst = 1;
  logic cs_n = 1, wr_n = 1, rd_n = 1, cd_sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] mode_q, cmd_q, sync1_q, sync2_q, tx_data;
  logic tx_wr_stb, rx_rd_stb, mode_done;

  ctl_write_seq uut (.clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cd_sel(cd_sel), .wdata(wdata), .mode_q(mode_q), .cmd_q(cmd_q), .sync1_q(sync1_q),
    .sync2_q(sync2_q), .tx_wr_stb(tx_wr_stb), .tx_data(tx_data), .rx_rd_stb(rx_rd_stb),
    .mode_done(mode_done));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int ntx = 0, nrx = 0;
  logic [7:0] last_tx = 0;
  int ms = 0;
  logic [7:0] em = 0, ec = 0, es1 = 0, es2 = 0;
  int etx = 0, erx = 0;
  logic [7:0] elast = 0;
  bit done = 0;

  always @(negedge clk) if (!rst) begin
    if (tx_wr_stb) begin ntx++; last_tx = tx_data; end
    if (rx_rd_stb) nrx++;
  end

  function automatic int next_after_mode(logic [7:0] d);
    return (d[1:0] == 2'b00 && d[7:6] != 2'b00) ? 1 : 3;
  endfunction

  function automatic int next_after_sync1(logic [7:0] m);
    return (m[7:6] >= 2'd2) ? 2 : 3;
  endfunction

  task automatic model_ctl(input logic [7:0] d);
    case (ms)
      0: begin em = d; ms = next_after_mode(d); end
      1: begin es1 = d; ms = next_after_sync1(em); end
      2: begin es2 = d; ms = 3; end
      default: if (d[6]) begin ec = 0; ms = 0; end else ec = d;
    endcase
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " mode_q"}, mode_q, em);
    chk({tag, " cmd_q"}, cmd_q, ec);
    chk({tag, " sync1_q"}, sync1_q, es1);
    chk({tag, " sync2_q"}, sync2_q, es2);
    chk({tag, " mode_done R10"}, mode_done, ms != 0);
    chk({tag, " tx pulses"}, ntx, etx);
    chk({tag, " rx pulses"}, nrx, erx);
    if (etx > 0) chk({tag, " tx_data"}, last_tx, elast);
  endtask

  task automatic bus_wr(input logic cs, input logic cd, input logic [7:0] d, input int hold);
    @(negedge clk);
    cs_n = cs; cd_sel = cd; wdata = d; wr_n = 0;
    repeat (hold) @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    cs_n = 1; wdata = 8'($urandom); cd_sel = 1'($urandom);
    repeat (6) @(negedge clk);
    if (!cs) begin
      if (cd) model_ctl(d);
      else if (ms != 0) begin etx++; elast = d; end
    end
  endtask

  task automatic bus_rd(input logic cs, input logic cd, input int hold);
    @(negedge clk);
    cs_n = cs; cd_sel = cd; rd_n = 0;
    repeat (hold) @(negedge clk);
    rd_n = 1;
    @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
    if (!cs && !cd) erx++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    check_all("R1 during reset");
    rst = 0;
    repeat (3) @(negedge clk);
    check_all("R1 after reset");

    bus_wr(0, 0, 8'h11, 2);           check_all("R6 data before mode");
    bus_wr(0, 1, 8'h4E, 2);           check_all("R2 async mode");
    bus_wr(0, 1, 8'h27, 1);           check_all("R3 command");
    bus_wr(0, 0, 8'hA5, 3);           check_all("R6 data write");
    bus_rd(0, 0, 2);                  check_all("R8 data read");
    bus_rd(0, 1, 2);                  check_all("R8 control read");
    bus_wr(1, 1, 8'h15, 2);           check_all("R7 deselected ctl");
    bus_wr(1, 0, 8'h3C, 2);           check_all("R7 deselected data");
    bus_rd(1, 0, 2);                  check_all("R7 deselected read");
    bus_wr(0, 0, 8'h5A, 20);          check_all("R9 long strobe data");
    bus_wr(0, 1, 8'h05, 25);          check_all("R9 long strobe ctl");
    bus_wr(0, 1, 8'h40, 1);           check_all("R5 internal reset");
    bus_wr(0, 1, 8'h80, 2);           check_all("R4 mode two syncs");
    bus_wr(0, 1, 8'h16, 2);           check_all("R4 sync1");
    bus_wr(0, 1, 8'h17, 2);           check_all("R4 sync2");
    bus_wr(0, 1, 8'h15, 2);           check_all("R4 cmd after syncs");
    bus_wr(0, 1, 8'h57, 2);           check_all("R5 irst from sync path");
    bus_wr(0, 1, 8'h44, 2);           check_all("R4 mode one sync");
    bus_wr(0, 1, 8'h33, 2);           check_all("R4 single sync");
    bus_wr(0, 1, 8'h25, 2);           check_all("R4 cmd after one sync");
    bus_wr(0, 1, 8'hFF, 2);           check_all("R5 irst again");
    bus_wr(0, 1, 8'h00, 2);           check_all("R4 mode zero syncs");
    bus_wr(0, 1, 8'h03, 2);           check_all("R4 cmd direct");

    for (int i = 0; i < 400; i++) begin
      int k;
      logic [7:0] d;
      k = int'($urandom % 10);
      d = 8'($urandom);
      if (ms == 3 && ($urandom % 6) != 0) d[6] = 1'b0;
      case (k)
        0, 1, 2, 3: bus_wr(0, 1, d, 1 + int'($urandom % 4));
        4, 5:       bus_wr(0, 0, d, 1 + int'($urandom % 4));
        6:          bus_rd(0, 0, 1 + int'($urandom % 3));
        7:          bus_rd(0, 1, 1 + int'($urandom % 3));
        8:          bus_wr(1, 1'($urandom), d, 1 + int'($urandom % 3));
        default:    bus_rd(1, 0, 1 + int'($urandom % 3));
      endcase
      check_all("R2 R3 R4 R5 R6 R7 R8 random");
    end

    rst = 1;
    repeat (3) @(negedge clk);
    ms = 0; em = 0; ec = 0; es1 = 0; es2 = 0;
    check_all("R1 second reset");
    finish_run();
  end
endmodule